// File: doc/BRIEF.md
# Indirect-Access Interrupt Redirection Router

The block routes up to 24 interrupt input pins towards processors. Each pin owns a 64-bit redirection entry that says how its interrupt is announced: the vector, a 3-bit delivery mode, a destination mode bit, the input polarity, edge or level triggering, a mask bit and an 8-bit destination. Software reaches the table only indirectly. It first writes a register number into a select byte, then reads or writes that register through a 32-bit data window. Each entry is split into a low and a high 32-bit half.

The block samples the pin levels and keeps one pending bit per pin. An edge-triggered pin latches a request on a rising input and drops it once its message has been accepted. A level-triggered pin is pending for as long as its input is high. A scanner picks one unmasked pending pin at a time, starting just after the pin it served last. It presents the entry's fields as a message on a valid/ready handshake. Resolving the destination and fetching vectors from a legacy controller are left to the logic downstream.

Top module: `ioxr_router`

## Requirements
- R1: Register offset 0x00 holds the 8-bit select value, which reads back in bits 7:0 with the upper bits zero. Offset 0x10 is the data window for the selected register. Any other offset reads 0, and writes to it are ignored. Reads are combinational on `reg_rdata_o`.
- R2: Select 0 is the identity register: bits 31:24 are writable and every other bit reads 0. Select 1 is read-only and returns 0x11 in bits 7:0 and (pin count − 1) in bits 23:16, which is 0x00170011 for 24 pins.
- R3: Select 0x10+2n reaches bits 31:0 of entry n and select 0x11+2n reaches bits 63:32. A write to one half leaves the other half unchanged.
- R4: Select values 0x02 to 0x0F, and any select whose entry index is 24 or more (0x40 and up), read 0 and ignore writes. No entry changes.
- R5: After reset every entry is 0x0000_0000_0001_0000, so every pin is masked. The select value and the identity are both 0, and no message is valid.
- R6: With bit 15 of its entry at 0, a pin is edge-triggered. One rising input edge yields exactly one message, however long the input stays high. The request is cleared when that message is accepted.
- R7: With bit 15 at 1, a pin is level-triggered. It stays pending while its input is high, so it is presented again after each acceptance. Once the input is low it produces no new message.
- R8: A pin whose entry has bit 16 set produces no message. An edge request that arrives while the pin is masked stays latched and is delivered after the mask is cleared.
- R9: Message fields are taken from the entry: vector = bits 7:0, delivery mode = bits 10:8, destination mode = bit 11, polarity = bit 13, trigger = bit 15, destination = bits 63:56. `msg_pin_o` carries the pin number.
- R10: Among unmasked pending pins, the first one in ascending order is chosen, starting at the pin after the last accepted one and wrapping past pin 23 to pin 0. After reset the search starts at pin 0.
- R11: Once `msg_valid_o` is high, the message stays valid and unchanged until `msg_ready_i` accepts it. Its fields are captured when it is loaded, so rewriting the entry afterwards does not alter it.
- R12: After each accepted message, `msg_valid_o` is low for at least one cycle. A pin that is always pending is therefore presented at most every second cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 5 | Register offset (0x00 select, 0x10 data) |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| irq_i | input | 24 | Interrupt input levels, one per pin |
| msg_valid_o | output | 1 | Delivery message valid |
| msg_ready_i | input | 1 | Downstream accepts the message |
| msg_pin_o | output | 5 | Pin that produced the message |
| msg_vector_o | output | 8 | Vector |
| msg_dlv_mode_o | output | 3 | Delivery mode |
| msg_dest_mode_o | output | 1 | Destination mode |
| msg_polarity_o | output | 1 | Polarity |
| msg_trig_o | output | 1 | Trigger mode, 1 = level |
| msg_dest_o | output | 8 | Destination |

## Verification
The bench targets five corner cases, each with a distinct failure.

1. Index decoding at the table boundary. Entry 23 high, at select 0x3F, must be writable, while selects 0x40 and 0x0F must be dead. A decoder that truncates or aliases the index would corrupt entry 0 or entry 8.
2. Half-word writes. A design that clears the other half on a write would lose the destination.
3. Edge requests. A pin held high for many cycles must give one message. A latch that followed the level would flood the queue. A pending pin that stays masked must keep its request, and a design that dropped it would never deliver after the unmask.
4. The rotating start. It is checked by raising pins on both sides of the last served pin, where a fixed-priority scan would reverse the order.
5. The level pin. It must re-present after acceptance, keep its captured vector while stalled, and stop once its input falls. A design that latched the entry live, or cleared level requests on acceptance, would show a wrong vector or a missing repeat.

// File: rtl/ioxr_pkg.sv
package ioxr_pkg;
  localparam int REG_W    = 32;
  localparam int ENTRY_W  = 64;
  localparam int SEL_W    = 8;
  localparam int ADDR_W   = 5;
  localparam logic [ADDR_W-1:0] OFS_SEL  = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_DATA = 5'h10;
  localparam logic [SEL_W-1:0]  SEL_ID   = 8'h00;
  localparam logic [SEL_W-1:0]  SEL_VER  = 8'h01;
  localparam logic [SEL_W-1:0]  SEL_TBL  = 8'h10;
  localparam logic [7:0]        VER_CODE = 8'h11;

  // entry field positions
  localparam int F_VEC_LO  = 0;
  localparam int F_DLV_LO  = 8;
  localparam int F_DMODE   = 11;
  localparam int F_POL     = 13;
  localparam int F_TRIG    = 15;
  localparam int F_MASK    = 16;
  localparam int F_DEST_LO = 56;

  localparam logic [ENTRY_W-1:0] ENTRY_RST = 64'h0000_0000_0001_0000;

  typedef struct packed {
    logic [7:0] vector;
    logic [2:0] dlv_mode;
    logic       dest_mode;
    logic       polarity;
    logic       trig;
    logic [7:0] dest;
  } msg_t;

  function automatic msg_t entry_to_msg(input logic [ENTRY_W-1:0] e);
    msg_t m;
    m.vector    = e[F_VEC_LO +: 8];
    m.dlv_mode  = e[F_DLV_LO +: 3];
    m.dest_mode = e[F_DMODE];
    m.polarity  = e[F_POL];
    m.trig      = e[F_TRIG];
    m.dest      = e[F_DEST_LO +: 8];
    return m;
  endfunction
endpackage

// File: rtl/ioxr_regs.sv
module ioxr_regs
  import ioxr_pkg::*;
#(
  parameter int NPINS = 24
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic                           we_i,
  input  logic [REG_W-1:0]               wdata_i,
  output logic [REG_W-1:0]               rdata_o,
  output logic [NPINS-1:0][ENTRY_W-1:0]  entry_o
);
  localparam logic [REG_W-1:0] VERSION = {8'h00, 8'(NPINS - 1), 8'h00, VER_CODE};

  logic [SEL_W-1:0] sel_q;
  logic [7:0]       id_q;
  logic [SEL_W-1:0] tbl_off;
  int               tbl_idx;
  logic             tbl_hi;
  logic             tbl_hit;
  logic             wr_sel, wr_data;

  assign wr_sel  = we_i && (addr_i == OFS_SEL);
  assign wr_data = we_i && (addr_i == OFS_DATA);
  assign tbl_off = sel_q - SEL_TBL;
  assign tbl_idx = int'(tbl_off[SEL_W-1:1]);
  assign tbl_hi  = tbl_off[0];
  assign tbl_hit = (sel_q >= SEL_TBL) && (tbl_idx < NPINS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      id_q  <= '0;
    end else begin
      if (wr_sel) sel_q <= wdata_i[SEL_W-1:0];
      if (wr_data && sel_q == SEL_ID) id_q <= wdata_i[31:24];
    end
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_entry
    logic hit;
    assign hit = wr_data && tbl_hit && (tbl_idx == g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        entry_o[g] <= ENTRY_RST;
      end else if (hit) begin
        if (tbl_hi) entry_o[g][63:32] <= wdata_i;
        else        entry_o[g][31:0]  <= wdata_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == OFS_SEL) begin
      rdata_o = {{(REG_W-SEL_W){1'b0}}, sel_q};
    end else if (addr_i == OFS_DATA) begin
      if (sel_q == SEL_ID) begin
        rdata_o = {id_q, 24'h0};
      end else if (sel_q == SEL_VER) begin
        rdata_o = VERSION;
      end else if (tbl_hit) begin
        for (int i = 0; i < NPINS; i++) begin
          if (tbl_idx == i) rdata_o = tbl_hi ? entry_o[i][63:32] : entry_o[i][31:0];
        end
      end
    end
  end
endmodule

// File: rtl/ioxr_pending.sv
module ioxr_pending #(
  parameter int NPINS = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] irq_i,
  input  logic [NPINS-1:0] trig_i,
  input  logic [NPINS-1:0] clr_i,
  output logic [NPINS-1:0] pend_o
);
  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic lvl_q, edge_q, rise;
    assign rise = irq_i[g] && !lvl_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lvl_q  <= 1'b0;
        edge_q <= 1'b0;
      end else begin
        lvl_q <= irq_i[g];
        // a new edge in the accept cycle wins over the clear
        if (rise && !trig_i[g]) edge_q <= 1'b1;
        else if (clr_i[g])      edge_q <= 1'b0;
      end
    end
    assign pend_o[g] = trig_i[g] ? lvl_q : edge_q;
  end
endmodule

// File: rtl/ioxr_scan.sv
module ioxr_scan
  import ioxr_pkg::*;
#(
  parameter int NPINS = 24,
  parameter int PINW  = $clog2(NPINS)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NPINS-1:0]              cand_i,
  input  logic [NPINS-1:0][ENTRY_W-1:0] entry_i,
  input  logic                          ready_i,
  output logic                          valid_o,
  output logic [PINW-1:0]               pin_o,
  output msg_t                          msg_o,
  output logic [NPINS-1:0]              clr_o
);
  logic [PINW-1:0]    ptr_q;
  logic [NPINS-1:0]   upper;
  logic [NPINS-1:0]   cand_hi;
  logic [PINW-1:0]    pick;
  logic               any;
  logic [ENTRY_W-1:0] pick_entry;
  logic               take;

  function automatic logic [PINW-1:0] first_one(input logic [NPINS-1:0] v);
    logic [PINW-1:0] r;
    r = '0;
    for (int i = NPINS - 1; i >= 0; i--) if (v[i]) r = PINW'(i);
    return r;
  endfunction

  always_comb begin
    for (int i = 0; i < NPINS; i++) upper[i] = (PINW'(i) >= ptr_q);
  end

  assign cand_hi = cand_i & upper;
  assign any     = |cand_i;
  assign pick    = (|cand_hi) ? first_one(cand_hi) : first_one(cand_i);
  assign take    = valid_o && ready_i;

  always_comb begin
    pick_entry = '0;
    for (int i = 0; i < NPINS; i++) if (PINW'(i) == pick) pick_entry = entry_i[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      pin_o   <= '0;
      msg_o   <= '0;
      ptr_q   <= '0;
    end else if (take) begin
      valid_o <= 1'b0;
      ptr_q   <= (pin_o == PINW'(NPINS - 1)) ? '0 : pin_o + 1'b1;
    end else if (!valid_o && any) begin
      valid_o <= 1'b1;
      pin_o   <= pick;
      msg_o   <= entry_to_msg(pick_entry);
    end
  end

  always_comb begin
    clr_o = '0;
    for (int i = 0; i < NPINS; i++) if (take && pin_o == PINW'(i)) clr_o[i] = 1'b1;
  end
endmodule

// File: rtl/ioxr_router.sv
module ioxr_router
  import ioxr_pkg::*;
#(
  parameter int NPINS = 24,
  parameter int PINW  = $clog2(NPINS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [4:0]        reg_addr_i,
  input  logic              reg_we_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic [NPINS-1:0]  irq_i,
  output logic              msg_valid_o,
  input  logic              msg_ready_i,
  output logic [PINW-1:0]   msg_pin_o,
  output logic [7:0]        msg_vector_o,
  output logic [2:0]        msg_dlv_mode_o,
  output logic              msg_dest_mode_o,
  output logic              msg_polarity_o,
  output logic              msg_trig_o,
  output logic [7:0]        msg_dest_o
);
  logic [NPINS-1:0][ENTRY_W-1:0] entry_w;
  logic [NPINS-1:0] mask_w, trig_w, pend_w, clr_w;
  msg_t msg_w;

  for (genvar g = 0; g < NPINS; g++) begin : g_fld
    assign mask_w[g] = entry_w[g][F_MASK];
    assign trig_w[g] = entry_w[g][F_TRIG];
  end

  ioxr_regs #(.NPINS(NPINS)) i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (reg_addr_i),
    .we_i    (reg_we_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .entry_o (entry_w)
  );

  ioxr_pending #(.NPINS(NPINS)) i_pending (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .irq_i  (irq_i),
    .trig_i (trig_w),
    .clr_i  (clr_w),
    .pend_o (pend_w)
  );

  ioxr_scan #(.NPINS(NPINS), .PINW(PINW)) i_scan (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cand_i  (pend_w & ~mask_w),
    .entry_i (entry_w),
    .ready_i (msg_ready_i),
    .valid_o (msg_valid_o),
    .pin_o   (msg_pin_o),
    .msg_o   (msg_w),
    .clr_o   (clr_w)
  );

  assign msg_vector_o    = msg_w.vector;
  assign msg_dlv_mode_o  = msg_w.dlv_mode;
  assign msg_dest_mode_o = msg_w.dest_mode;
  assign msg_polarity_o  = msg_w.polarity;
  assign msg_trig_o      = msg_w.trig;
  assign msg_dest_o      = msg_w.dest;
endmodule

// File: rtl/ioxr_router_chk.sv
module ioxr_router_chk #(
  parameter int NPINS = 24,
  parameter int PINW  = $clog2(NPINS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic             ready_i,
  input logic [PINW-1:0]  pin_i,
  input logic [22:0]      payload_i,
  input logic [NPINS-1:0] cand_i
);
  logic [NPINS-1:0] cand_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cand_q <= '0;
    else         cand_q <= cand_i;
  end

  // R11: held message is stable until accepted
  a_r11_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !ready_i |=> valid_i && $stable(pin_i) && $stable(payload_i));

  // R8: a newly loaded message comes from a pin that was pending and unmasked
  a_r8_from_candidate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_i) |-> cand_q[pin_i]);

  // R12: idle cycle after every acceptance
  a_r12_gap_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ready_i |=> !valid_i);

  // R10: reported pin lies inside the table
  a_r10_pin_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> int'(pin_i) < NPINS);
endmodule

bind ioxr_router ioxr_router_chk #(.NPINS(NPINS), .PINW(PINW)) i_ioxr_router_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (msg_valid_o),
  .ready_i   (msg_ready_i),
  .pin_i     (msg_pin_o),
  .payload_i ({msg_vector_o, msg_dlv_mode_o, msg_dest_mode_o, msg_polarity_o,
               msg_trig_o, msg_dest_o}),
  .cand_i    (pend_w & ~mask_w)
);

// File: tb/test_ioxr_router.sv
module test_ioxr_router;
  localparam int NP = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NP-1:0] irq = '0;
  logic        msg_valid, msg_ready = 1'b1;
  logic [4:0]  msg_pin;
  logic [7:0]  msg_vector, msg_dest;
  logic [2:0]  msg_dlv;
  logic        msg_dmode, msg_pol, msg_trig;

  int n_chk = 0;
  int n_bad = 0;
  bit mon_en = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  ioxr_router i_ioxr_router (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_i(irq),
    .msg_valid_o(msg_valid), .msg_ready_i(msg_ready), .msg_pin_o(msg_pin),
    .msg_vector_o(msg_vector), .msg_dlv_mode_o(msg_dlv),
    .msg_dest_mode_o(msg_dmode), .msg_polarity_o(msg_pol),
    .msg_trig_o(msg_trig), .msg_dest_o(msg_dest)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h exp %h", tag, act, exp);
    end
  endtask

  // R9 field layout applied to an entry
  function automatic logic [31:0] pk(input int pin, input logic [31:0] lo, input logic [31:0] hi);
    return {5'd0, 5'(pin), lo[7:0], lo[10:8], lo[11], lo[13], lo[15], hi[31:24]};
  endfunction

  function automatic logic [31:0] act_msg();
    return {5'd0, msg_pin, msg_vector, msg_dlv, msg_dmode, msg_pol, msg_trig, msg_dest};
  endfunction

  task automatic reg_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic reg_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic sel_rd(input logic [7:0] s, output logic [31:0] d);
    reg_wr(5'h00, {24'h0, s});
    reg_rd(5'h10, d);
  endtask

  task automatic prog(input int pin, input logic [31:0] lo, input logic [31:0] hi);
    reg_wr(5'h00, 32'(8'h10 + 2 * pin)); reg_wr(5'h10, lo);
    reg_wr(5'h00, 32'(8'h11 + 2 * pin)); reg_wr(5'h10, hi);
  endtask

  task automatic expect_msg(input int pin, input logic [31:0] lo, input logic [31:0] hi, input string tag);
    exp_q.push_back(pk(pin, lo, hi));
    tag_q.push_back(tag);
  endtask

  task automatic pulse(input logic [NP-1:0] m);
    @(negedge clk); irq = irq | m;
    @(negedge clk); irq = irq & ~m;
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (exp_q.size() == 0) break;
    end
    repeat (4) @(negedge clk);
    chk(tag, 32'(exp_q.size()), 32'd0);
  endtask

  task automatic idle(input int n, input string tag);
    logic seen;
    seen = 1'b0;
    repeat (n) begin @(negedge clk); #1 seen = seen | msg_valid; end
    chk(tag, {31'd0, seen}, 32'd0);
  endtask

  // scoreboard monitor
  always begin
    @(negedge clk); #1;
    if (rst_n && mon_en && msg_valid && msg_ready) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R6 unexpected message: got %h exp none", act_msg());
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, act_msg(), e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R5 reset state
    #1 chk("R5 valid after reset", {31'd0, msg_valid}, 32'd0);
    reg_rd(5'h00, d);  chk("R5 select reset", d, 32'h0);
    reg_rd(5'h10, d);  chk("R5 id reset", d, 32'h0);
    sel_rd(8'h10, d);  chk("R5 entry0 low", d, 32'h0001_0000);
    sel_rd(8'h11, d);  chk("R5 entry0 high", d, 32'h0);
    sel_rd(8'h3E, d);  chk("R5 entry23 low", d, 32'h0001_0000);

    // R2 identity and version
    sel_rd(8'h01, d);  chk("R2 version", d, 32'h0017_0011);
    reg_wr(5'h10, 32'hFFFF_FFFF);
    reg_rd(5'h10, d);  chk("R2 version read-only", d, 32'h0017_0011);
    reg_wr(5'h00, 32'h0); reg_wr(5'h10, 32'hA512_3456);
    reg_rd(5'h10, d);  chk("R2 id bits", d, 32'hA500_0000);

    // R1 offsets
    reg_wr(5'h04, 32'h0000_0011);
    reg_rd(5'h04, d);  chk("R1 other offset reads 0", d, 32'h0);
    reg_rd(5'h00, d);  chk("R1 other offset write ignored", d, 32'h0);
    reg_wr(5'h00, 32'h0000_01FF);
    reg_rd(5'h00, d);  chk("R1 select is 8 bits", d, 32'h0000_00FF);

    // R3 halves
    prog(1, 32'h1234_5678, 32'h9ABC_DEF0);
    sel_rd(8'h12, d);  chk("R3 entry1 low", d, 32'h1234_5678);
    sel_rd(8'h13, d);  chk("R3 entry1 high", d, 32'h9ABC_DEF0);
    reg_wr(5'h00, 32'h12); reg_wr(5'h10, 32'h0001_0000);
    sel_rd(8'h13, d);  chk("R3 high kept after low write", d, 32'h9ABC_DEF0);
    reg_wr(5'h00, 32'h3F); reg_wr(5'h10, 32'hCAFE_0000);
    sel_rd(8'h3F, d);  chk("R3 entry23 high", d, 32'hCAFE_0000);
    sel_rd(8'h3E, d);  chk("R3 entry23 low kept", d, 32'h0001_0000);

    // R4 dead selects
    reg_wr(5'h00, 32'h40); reg_wr(5'h10, 32'hDEAD_BEEF);
    reg_rd(5'h10, d);  chk("R4 sel 0x40 reads 0", d, 32'h0);
    reg_wr(5'h00, 32'h0F); reg_wr(5'h10, 32'hDEAD_BEEF);
    reg_rd(5'h10, d);  chk("R4 sel 0x0F reads 0", d, 32'h0);
    sel_rd(8'h10, d);  chk("R4 entry0 untouched", d, 32'h0001_0000);
    sel_rd(8'h20, d);  chk("R4 entry8 untouched", d, 32'h0001_0000);
    sel_rd(8'h3F, d);  chk("R4 entry23 untouched", d, 32'hCAFE_0000);
    reg_wr(5'h00, 32'h13); reg_wr(5'h10, 32'h0);

    // R6 R9 R10 edge delivery in ascending order
    mon_en = 1'b1;
    msg_ready = 1'b1;
    prog(3, 32'h0000_0931, 32'h5A00_0000);
    prog(7, 32'h0000_2047, 32'h0300_0000);
    expect_msg(3, 32'h0000_0931, 32'h5A00_0000, "R9 pin3 fields");
    expect_msg(7, 32'h0000_2047, 32'h0300_0000, "R10 pin7 after pin3");
    pulse(24'h000088);
    drain("R6 edge pair drained");
    idle(10, "R6 no repeat after edge");

    // R10 rotation: last served 7, so 9 before 2
    prog(2, 32'h0000_0022, 32'h2200_0000);
    prog(9, 32'h0000_0099, 32'h9900_0000);
    expect_msg(9, 32'h0000_0099, 32'h9900_0000, "R10 pin9 first after 7");
    expect_msg(2, 32'h0000_0022, 32'h2200_0000, "R10 pin2 after wrap");
    pulse(24'h000204);
    drain("R10 rotation drained");

    // R8 masked pin keeps request
    prog(5, 32'h0001_0055, 32'h1100_0000);
    pulse(24'h000020);
    idle(20, "R8 masked pin silent");
    expect_msg(5, 32'h0000_0055, 32'h1100_0000, "R8 delivered after unmask");
    reg_wr(5'h00, 32'h1A); reg_wr(5'h10, 32'h0000_0055);
    drain("R8 unmask drained");

    // R6 held-high edge pin gives one message
    expect_msg(3, 32'h0000_0931, 32'h5A00_0000, "R6 single message on long high");
    @(negedge clk); irq[3] = 1'b1;
    repeat (20) @(negedge clk);
    irq[3] = 1'b0;
    drain("R6 long high drained");

    // R7 R11 level pin
    msg_ready = 1'b0;
    prog(12, 32'h0000_80C0, 32'h7700_0000);
    @(negedge clk); irq[12] = 1'b1;
    repeat (4) @(negedge clk);
    #1 chk("R7 level pin presented", {31'd0, msg_valid}, 32'd1);
    chk("R9 trig bit level", {31'd0, msg_trig}, 32'd1);
    expect_msg(12, 32'h0000_80C0, 32'h7700_0000, "R11 captured vector");
    reg_wr(5'h00, 32'h28); reg_wr(5'h10, 32'h0000_80C1);
    #1 chk("R11 vector held while stalled", {24'd0, msg_vector}, 32'h0000_00C0);
    @(negedge clk); msg_ready = 1'b1;
    @(negedge clk); msg_ready = 1'b0;
    repeat (4) @(negedge clk);
    #1 chk("R7 level re-presented", {31'd0, msg_valid}, 32'd1);
    expect_msg(12, 32'h0000_80C1, 32'h7700_0000, "R7 second level message");
    @(negedge clk); irq[12] = 1'b0;
    repeat (3) @(negedge clk);
    #1 chk("R11 held after input drop", {31'd0, msg_valid}, 32'd1);
    @(negedge clk); msg_ready = 1'b1;
    drain("R7 level drained");
    idle(8, "R7 silent after level low");

    // R12 every-second-cycle cadence on a level pin
    mon_en = 1'b0;
    @(negedge clk); irq[12] = 1'b1;
    repeat (4) @(negedge clk);
    begin
      int cnt;
      cnt = 0;
      repeat (10) begin @(negedge clk); #1 if (msg_valid) cnt++; end
      chk("R12 valid every second cycle", 32'(cnt), 32'd5);
    end
    @(negedge clk); irq[12] = 1'b0;
    repeat (6) @(negedge clk);
    idle(6, "R12 quiet after cadence");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule